// File: doc/BRIEF.md
# Infrared Mark and Symbol-Period Capture Receiver

This block is the front end of a remote-control receiver. It takes one already demodulated input line, where the active level means that a carrier is present. It samples that line on a tick that is derived from the system clock by a programmable divisor. With the usual divisor choice the tick runs at about 10 MHz, which gives 100 ns resolution.

For every symbol the block measures two values. The first is how many ticks the line was active: the mark. The second is how many ticks passed from the start of that mark to the start of the next one: the symbol period. Software derives the space as period minus mark. Each mark/period pair goes into an eight-entry FIFO. If no new mark starts before the period reaches a programmable limit, the block stores the pair with the period forced to all ones, which marks the last symbol of a train. The receiver then waits for the next train.

Software controls the block through a small word-addressed register port. Registers cover enable, input inversion, the sample divisor, the period limit, interrupt enables, interrupt status and interrupt clear, together with a FIFO status word and the two data words at the FIFO head. A single interrupt line is raised from the status bits that are enabled.

Top module: `irx_capture`

## Requirements
- R1: After reset the control (0x0), divisor (0x1), interrupt enable (0x3), interrupt status (0x4) and FIFO status (0x6) registers read 0, the period limit register (0x2) reads 0xFFFF, and `irq` is low.
- R2: The sample tick occurs once every N clock cycles, where N is the value in the divisor register; a value of 0 or 1 gives a tick every cycle. All mark and period values are counted in ticks.
- R3: The mark value is the number of ticks the line was active within a symbol. The period value is the number of ticks from the tick on which a mark starts up to, but not including, the tick on which the next mark starts.
- R4: If the period of a symbol would reach the period limit before a new mark starts, the block stores that symbol with period 0xFFFF and its mark so far, and waits for a new mark. A period of limit minus 1 is still stored as measured. Storing a 0xFFFF entry sets status bit 1.
- R5: Control bit 1 set means the line is active low; control bit 1 clear means the line is active high.
- R6: Control bit 0 enables capture. While it is clear no entry is stored, no status bit is set, and any symbol in progress is abandoned.
- R7: The FIFO holds 8 entries. Register 0x7 returns the head mark in bits 15:0 without side effect. Register 0x8 returns the head period in bits 15:0, and reading it removes the head entry.
- R8: A symbol that completes while the FIFO holds 8 entries, with no removal in the same cycle, is dropped. The drop sets status bit 2, which also reads as bit 2 of the FIFO status register.
- R9: Status bit 0 is set on every stored entry, and status bit 3 is set when the FIFO becomes full. Writing ones to the clear register (0x5) clears the matching status bits. A bit that is set in the same cycle as its clear stays set.
- R10: `irq` is high exactly when some status bit and the matching bit of the enable register (0x3) are both 1.
- R11: Bits 15:8 of the FIFO status register hold the number of stored entries.
- R12: When a symbol completes in the same cycle that a head removal occurs on a full FIFO, both take effect: the FIFO stays at 8 entries and no overrun is flagged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| rx_in | input | 1 | Demodulated receive line, asynchronous |
| reg_wr | input | 1 | Register write strobe, one cycle per write |
| reg_rd | input | 1 | Register read strobe, one cycle per read |
| reg_addr | input | 4 | Word address of the register |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, valid in the cycle of `reg_rd` |
| irq | output | 1 | Interrupt request, level |

## Verification
The two functions that can fall in the same cycle are the completion of a symbol, which pushes an entry, and a period read, which removes the head. The case that matters is the one with a full FIFO. The bench fills the FIFO to eight entries. It then starts the tenth mark with the line edge placed so that the resulting push lands exactly on the clock edge where a period read is issued, two cycles behind the synchronizer. The case is judged by the overrun bit staying clear, the occupancy staying at eight, and the drained entries all carrying the expected mark and period.

// File: rtl/irx_pkg.sv
package irx_pkg;

    localparam int CNT_W = 16;

    typedef logic [CNT_W-1:0] cnt_t;

    typedef struct packed {
        cnt_t mark;
        cnt_t period;
    } sym_entry_t;

    typedef enum logic [0:0] {
        S_IDLE = 1'b0,
        S_MEAS = 1'b1
    } meas_state_t;

    localparam logic [3:0] A_CTRL   = 4'h0;
    localparam logic [3:0] A_DIV    = 4'h1;
    localparam logic [3:0] A_MAXPER = 4'h2;
    localparam logic [3:0] A_IEN    = 4'h3;
    localparam logic [3:0] A_ISTAT  = 4'h4;
    localparam logic [3:0] A_ICLR   = 4'h5;
    localparam logic [3:0] A_FSTAT  = 4'h6;
    localparam logic [3:0] A_MARK   = 4'h7;
    localparam logic [3:0] A_PER    = 4'h8;

    localparam int IB_DATA = 0;
    localparam int IB_LAST = 1;
    localparam int IB_OVR  = 2;
    localparam int IB_FULL = 3;

    function automatic cnt_t sat_inc(input cnt_t v);
        return (v == '1) ? v : v + cnt_t'(1);
    endfunction

endpackage

// File: rtl/irx_tick_gen.sv
module irx_tick_gen #(
    parameter int DIV_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [DIV_W-1:0] div,
    output logic             tick
);
    logic [DIV_W-1:0] cnt_q;
    logic [DIV_W-1:0] lim;

    // A divisor of 0 behaves as 1
    assign lim  = (div == '0) ? '0 : div - DIV_W'(1);
    assign tick = (cnt_q >= lim);

    always_ff @(posedge clk) begin
        if (rst)       cnt_q <= '0;
        else if (tick) cnt_q <= '0;
        else           cnt_q <= cnt_q + DIV_W'(1);
    end
endmodule

// File: rtl/irx_symbol_meas.sv
module irx_symbol_meas
    import irx_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       en,
    input  logic       tick,
    input  logic       level,
    input  cnt_t       maxper,
    output logic       push,
    output sym_entry_t entry
);
    meas_state_t st_q, st_d;
    cnt_t        mark_q, mark_d;
    cnt_t        per_q, per_d;
    logic        prev_q;
    logic        rise;

    assign rise = level && !prev_q;

    always_comb begin
        st_d   = st_q;
        mark_d = mark_q;
        per_d  = per_q;
        push   = 1'b0;
        entry  = '{mark: mark_q, period: per_q};
        if (!en) begin
            st_d = S_IDLE;
        end else if (tick) begin
            case (st_q)
                S_IDLE: begin
                    if (rise) begin
                        st_d   = S_MEAS;
                        mark_d = cnt_t'(1);
                        per_d  = cnt_t'(1);
                    end
                end
                S_MEAS: begin
                    if (rise) begin
                        push   = 1'b1;
                        mark_d = cnt_t'(1);
                        per_d  = cnt_t'(1);
                    end else begin
                        per_d = sat_inc(per_q);
                        if (level) mark_d = sat_inc(mark_q);
                        if (per_d >= maxper) begin
                            push  = 1'b1;
                            entry = '{mark: mark_d, period: '1};
                            st_d  = S_IDLE;
                        end
                    end
                end
                default: st_d = S_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q   <= S_IDLE;
            mark_q <= '0;
            per_q  <= '0;
            prev_q <= 1'b0;
        end else begin
            st_q   <= st_d;
            mark_q <= mark_d;
            per_q  <= per_d;
            if (tick) prev_q <= level;
        end
    end
endmodule

// File: rtl/irx_entry_fifo.sv
module irx_entry_fifo
    import irx_pkg::*;
#(
    parameter int DEPTH = 8,
    localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CW = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          push,
    input  sym_entry_t    wentry,
    input  logic          pop,
    output sym_entry_t    head,
    output logic [CW-1:0] cnt,
    output logic          acc,
    output logic          drop,
    output logic          fill_evt
);
    sym_entry_t    mem [DEPTH];
    logic [PW-1:0] wptr_q, rptr_q;
    logic [CW-1:0] cnt_q;
    logic          full, pop_ok;

    function automatic logic [PW-1:0] nxt(input logic [PW-1:0] p);
        return (p == PW'(DEPTH - 1)) ? '0 : p + PW'(1);
    endfunction

    assign full     = (cnt_q == CW'(DEPTH));
    assign pop_ok   = pop && (cnt_q != '0);
    assign acc      = push && (!full || pop_ok);
    assign drop     = push && !acc;
    assign fill_evt = acc && !pop_ok && (cnt_q == CW'(DEPTH - 1));
    assign head     = mem[rptr_q];
    assign cnt      = cnt_q;

    always_ff @(posedge clk) begin
        if (acc) mem[wptr_q] <= wentry;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wptr_q <= '0;
            rptr_q <= '0;
            cnt_q  <= '0;
        end else begin
            if (acc)    wptr_q <= nxt(wptr_q);
            if (pop_ok) rptr_q <= nxt(rptr_q);
            case ({acc, pop_ok})
                2'b10:   cnt_q <= cnt_q + CW'(1);
                2'b01:   cnt_q <= cnt_q - CW'(1);
                default: cnt_q <= cnt_q;
            endcase
        end
    end
endmodule

// File: rtl/irx_capture.sv
module irx_capture
    import irx_pkg::*;
#(
    parameter int DIV_W       = 16,
    parameter int FIFO_DEPTH  = 8,
    parameter int SYNC_STAGES = 2,
    localparam int CW = $clog2(FIFO_DEPTH + 1)
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        rx_in,
    input  logic        reg_wr,
    input  logic        reg_rd,
    input  logic [3:0]  reg_addr,
    input  logic [31:0] reg_wdata,
    output logic [31:0] reg_rdata,
    output logic        irq
);
    logic [SYNC_STAGES-1:0] sync_q;
    logic                   ctrl_en, ctrl_inv;
    logic [DIV_W-1:0]       div_q;
    cnt_t                   maxper_q;
    logic [3:0]             ien_q, istat_q, istat_set, istat_clr;
    logic                   tick, level;
    logic                   meas_push, pop_req;
    sym_entry_t             meas_entry, head;
    logic [CW-1:0]          fifo_cnt;
    logic                   fifo_acc, fifo_drop, fifo_fill;
    logic                   unused_wdata;

    assign unused_wdata = ^reg_wdata[31:16];

    // Input synchronizer
    always_ff @(posedge clk) begin
        if (rst) sync_q <= '0;
        else     sync_q <= {sync_q[SYNC_STAGES-2:0], rx_in};
    end

    assign level = sync_q[SYNC_STAGES-1] ^ ctrl_inv;

    irx_tick_gen #(.DIV_W(DIV_W)) u_tick (
        .clk  (clk),
        .rst  (rst),
        .div  (div_q),
        .tick (tick)
    );

    irx_symbol_meas u_meas (
        .clk    (clk),
        .rst    (rst),
        .en     (ctrl_en),
        .tick   (tick),
        .level  (level),
        .maxper (maxper_q),
        .push   (meas_push),
        .entry  (meas_entry)
    );

    assign pop_req = reg_rd && (reg_addr == A_PER);

    irx_entry_fifo #(.DEPTH(FIFO_DEPTH)) u_fifo (
        .clk      (clk),
        .rst      (rst),
        .push     (meas_push),
        .wentry   (meas_entry),
        .pop      (pop_req),
        .head     (head),
        .cnt      (fifo_cnt),
        .acc      (fifo_acc),
        .drop     (fifo_drop),
        .fill_evt (fifo_fill)
    );

    // Interrupt status sources
    always_comb begin
        istat_set          = '0;
        istat_set[IB_DATA] = fifo_acc;
        istat_set[IB_LAST] = fifo_acc && (meas_entry.period == '1);
        istat_set[IB_OVR]  = fifo_drop;
        istat_set[IB_FULL] = fifo_fill;
    end

    assign istat_clr = (reg_wr && reg_addr == A_ICLR) ? reg_wdata[3:0] : 4'h0;

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_en  <= 1'b0;
            ctrl_inv <= 1'b0;
            div_q    <= '0;
            maxper_q <= '1;
            ien_q    <= '0;
            istat_q  <= '0;
        end else begin
            istat_q <= (istat_q & ~istat_clr) | istat_set;
            if (reg_wr) begin
                case (reg_addr)
                    A_CTRL: begin
                        ctrl_en  <= reg_wdata[0];
                        ctrl_inv <= reg_wdata[1];
                    end
                    A_DIV:    div_q    <= reg_wdata[DIV_W-1:0];
                    A_MAXPER: maxper_q <= reg_wdata[CNT_W-1:0];
                    A_IEN:    ien_q    <= reg_wdata[3:0];
                    default:  ;
                endcase
            end
        end
    end

    always_comb begin
        reg_rdata = '0;
        case (reg_addr)
            A_CTRL:   reg_rdata[1:0]       = {ctrl_inv, ctrl_en};
            A_DIV:    reg_rdata[DIV_W-1:0] = div_q;
            A_MAXPER: reg_rdata[CNT_W-1:0] = maxper_q;
            A_IEN:    reg_rdata[3:0]       = ien_q;
            A_ISTAT:  reg_rdata[3:0]       = istat_q;
            A_FSTAT: begin
                reg_rdata[15:8] = 8'(fifo_cnt);
                reg_rdata[2]    = istat_q[IB_OVR];
            end
            A_MARK:   reg_rdata[CNT_W-1:0] = head.mark;
            A_PER:    reg_rdata[CNT_W-1:0] = head.period;
            default:  reg_rdata = '0;
        endcase
    end

    assign irq = |(istat_q & ien_q);
endmodule

// File: rtl/irx_capture_chk.sv
module irx_capture_chk #(
    parameter int DEPTH = 8,
    parameter int CW    = 4
) (
    input logic          clk,
    input logic          rst,
    input logic          en,
    input logic          push,
    input logic          pop,
    input logic          acc,
    input logic [CW-1:0] cnt,
    input logic [15:0]   per,
    input logic [3:0]    istat
);
    // R7
    occupancy_bound_chk: assert property (@(posedge clk) disable iff (rst)
        cnt <= CW'(DEPTH));

    // R6
    disabled_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        !en |-> !push);

    // R8
    overrun_flag_chk: assert property (@(posedge clk) disable iff (rst)
        (push && cnt == CW'(DEPTH) && !pop) |=> istat[2]);

    // R12
    push_pop_full_chk: assert property (@(posedge clk) disable iff (rst)
        (push && pop && cnt == CW'(DEPTH)) |=> (cnt == CW'(DEPTH)));

    // R4
    last_flag_chk: assert property (@(posedge clk) disable iff (rst)
        (acc && per == 16'hFFFF) |=> istat[1]);

    // R7
    pop_dec_chk: assert property (@(posedge clk) disable iff (rst)
        (pop && cnt != '0 && !push) |=> (cnt == $past(cnt) - CW'(1)));
endmodule

bind irx_capture irx_capture_chk #(.DEPTH(FIFO_DEPTH), .CW(CW)) u_chk (
    .clk   (clk),
    .rst   (rst),
    .en    (ctrl_en),
    .push  (meas_push),
    .pop   (pop_req),
    .acc   (fifo_acc),
    .cnt   (fifo_cnt),
    .per   (meas_entry.period),
    .istat (istat_q)
);

// File: tb/irx_capture_bench.sv
module irx_capture_bench;
    localparam int CLK_PERIOD = 10;
    localparam int MAXP       = 200;
    localparam int NV         = 8;
    // divisor, invert, mark ticks, period ticks, expected first period
    localparam int VEC [NV][5] = '{
        '{1, 0, 3,  10,  10},
        '{3, 0, 5,  12,  12},
        '{1, 1, 4,  9,   9},
        '{5, 1, 2,  20,  20},
        '{1, 0, 7,  199, 199},
        '{2, 0, 6,  200, 32'hFFFF},
        '{1, 0, 1,  2,   2},
        '{4, 1, 10, 11,  11}
    };
    localparam logic [3:0] R_CTRL = 4'h0, R_DIV = 4'h1, R_MAXP = 4'h2, R_IEN = 4'h3,
                           R_IST = 4'h4, R_CLR = 4'h5, R_FST = 4'h6, R_MRK = 4'h7,
                           R_PER = 4'h8;

    logic        clk = 1'b0, rst = 1'b1, rx_in = 1'b0;
    logic        reg_wr = 1'b0, reg_rd = 1'b0;
    logic [3:0]  reg_addr = 4'h0;
    logic [31:0] reg_wdata = 32'h0;
    logic [31:0] reg_rdata;
    logic        irq;
    int          nvec = 0, nfail = 0;
    bit          done = 1'b0;

    irx_capture u_irx_capture (
        .clk(clk), .rst(rst), .rx_in(rx_in), .reg_wr(reg_wr), .reg_rd(reg_rd),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        nvec++;
        if (act !== exp) begin
            nfail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic wr(logic [3:0] a, logic [31:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(logic [3:0] a, output logic [31:0] d);
        @(negedge clk);
        reg_rd = 1'b1; reg_addr = a;
        #1 d = reg_rdata;
        @(negedge clk);
        reg_rd = 1'b0;
    endtask

    task automatic drive(logic lvl, int n);
        rx_in = lvl;
        repeat (n) @(negedge clk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            nfail++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
            $finish;
        end
    end

    initial begin
        logic [31:0] d;
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1 reset state
        rd(R_CTRL, d); check("R1 ctrl", d, 0);
        rd(R_DIV, d);  check("R1 div", d, 0);
        rd(R_MAXP, d); check("R1 maxper", d, 32'hFFFF);
        rd(R_IEN, d);  check("R1 ien", d, 0);
        rd(R_IST, d);  check("R1 istat", d, 0);
        rd(R_FST, d);  check("R1 fstat", d, 0);
        check("R1 irq", {31'b0, irq}, 0);

        wr(R_MAXP, MAXP);

        // Vector table: R2 R3 R4 R5 R7 R11
        for (int v = 0; v < NV; v++) begin
            int dv, inv, mk, pr;
            dv = VEC[v][0]; inv = VEC[v][1]; mk = VEC[v][2]; pr = VEC[v][3];
            wr(R_CTRL, 0);
            drive(inv[0], 3 * dv + 4);
            wr(R_DIV, dv);
            wr(R_CTRL, {30'b0, inv[0], 1'b1});
            drive(inv[0], 2 * dv + 2);
            drive(!inv[0], mk * dv);
            drive(inv[0], (pr - mk) * dv);
            drive(!inv[0], dv);
            drive(inv[0], (MAXP + 5) * dv + 10);
            rd(R_FST, d); check("R11 occupancy two", d, 32'h200);
            rd(R_IST, d); check("R4 last-symbol status", d, 32'h3);
            rd(R_MRK, d); check("R3 R5 mark", d, mk);
            rd(R_PER, d); check("R2 R3 R4 period", d, VEC[v][4]);
            rd(R_MRK, d); check("R4 final mark", d, 1);
            rd(R_PER, d); check("R4 final period", d, 32'hFFFF);
            rd(R_FST, d); check("R7 R11 drained", d, 0);
            wr(R_CLR, 32'hF);
        end

        // R6 disabled capture
        wr(R_CTRL, 0);
        wr(R_DIV, 1);
        for (int i = 0; i < 3; i++) begin drive(1'b1, 4); drive(1'b0, 4); end
        drive(1'b0, MAXP + 20);
        rd(R_FST, d); check("R6 no entries", d, 0);
        rd(R_IST, d); check("R6 no status", d, 0);

        // R8 R9 R10 overrun and full
        wr(R_CTRL, 1);
        wr(R_IEN, 32'h4);
        drive(1'b0, 4);
        for (int i = 0; i < 10; i++) begin drive(1'b1, 3); drive(1'b0, 3); end
        drive(1'b0, MAXP + 10);
        rd(R_IST, d); check("R8 R9 status", d, 32'hD);
        rd(R_FST, d); check("R8 R11 fstat", d, 32'h804);
        check("R10 irq on overrun", {31'b0, irq}, 1);
        wr(R_CLR, 32'h4);
        rd(R_IST, d); check("R9 clear overrun", d, 32'h9);
        check("R10 irq masked", {31'b0, irq}, 0);
        wr(R_IEN, 32'h8);
        check("R10 irq on full", {31'b0, irq}, 1);
        wr(R_CLR, 32'hF);
        wr(R_IEN, 0);
        rd(R_IST, d); check("R9 clear all", d, 0);
        for (int i = 0; i < 8; i++) begin
            rd(R_MRK, d); check("R7 drain mark", d, 3);
            rd(R_PER, d); check("R7 drain period", d, 6);
        end
        rd(R_FST, d); check("R11 empty", d, 0);

        // R12 push and pop on the same edge with a full FIFO
        wr(R_CTRL, 0);
        wr(R_CTRL, 1);
        drive(1'b0, 4);
        for (int i = 0; i < 9; i++) begin drive(1'b1, 3); drive(1'b0, 3); end
        rx_in = 1'b1;
        @(negedge clk);
        @(negedge clk);
        reg_rd = 1'b1; reg_addr = R_PER;
        #1 d = reg_rdata;
        check("R12 popped period", d, 6);
        @(negedge clk);
        reg_rd = 1'b0;
        rd(R_IST, d); check("R12 no overrun", d & 32'h4, 0);
        rd(R_FST, d); check("R12 still full", d, 32'h800);
        wr(R_CTRL, 0);
        rx_in = 1'b0;
        for (int i = 0; i < 8; i++) begin
            rd(R_MRK, d); check("R12 drain mark", d, 3);
            rd(R_PER, d); check("R12 drain period", d, 6);
        end

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
        $finish;
    end
endmodule